// File: doc/BRIEF.md
# Multi-CPU Interrupt Controller Core

This block collects level interrupt requests and steers them to up to four processor cores. Every source is sampled into a register once per clock. Sources numbered below 32 are private: each core has its own 32 private inputs and its own mask for them. Sources numbered 32 and above are shared: one global enable per source, and a routing word per source with one bit per core that picks which cores may see it.

Software reaches the block through a single 32-bit register port. A region-select input chooses between the global region and the banked per-core region. In the banked region, address bits [9:8] pick the core. Enables and masks are not written as bitmaps. Software writes the source number to a dedicated set register or clear register. Each core has an acknowledge register that names the lowest-numbered source deliverable to it. Each core also has a level IRQ output that is high whenever any source is deliverable to it.

Top module: `icc_top`

## Requirements
- R1: After reset the controller is disabled, every shared source is disabled, every private source is masked on every core, every routing word reads 0, the priority register of each core reads 0xF, every IRQ output is low and every acknowledge read returns 0x3FF.
- R2: Global offset 0x000 holds the controller enable in bit 0 (written from write-data bit 0). On a read, bits [11:2] give the number of implemented sources and the other bits read 0. While the enable is 0, no IRQ output is high and every acknowledge read returns 0x3FF.
- R3: In the global region, writing a source number n to offset 0x030 enables shared source n, and writing it to offset 0x034 disables it. A number below 32, or one at or above the source count, changes nothing.
- R4: In core c's bank, writing a number n below 32 to offset 0x04C unmasks private source n for core c only, and writing it to offset 0x048 masks it. A number of 32 or more changes nothing.
- R5: The routing word of source n is at global offset 0x100 + 4*n. Bits [NCPU-1:0] are stored and read back, and all other bits read 0. A shared source reaches core c only when bit c of its routing word is 1. Routing words have no effect on private sources.
- R6: Reading offset 0x044 in core c's bank returns, in bits [9:0], the lowest-numbered source deliverable to core c, or 0x3FF when there is none. Bits [31:10] read 0. A source is deliverable when the controller is enabled and either (a) it is a private source that is pending and unmasked, or (b) it is a shared source that is pending, enabled and routed to core c.
- R7: Core c's IRQ output is high exactly when at least one source is deliverable to core c.
- R8: Offset 0x010 in core c's bank reads as a bitmap of core c's sampled private inputs, with bit n for source n, whatever the mask state.
- R9: Offset 0x040 in core c's bank is a 4-bit task-priority register. It stores write-data bits [3:0], reads back in bits [3:0], and has no effect on delivery.
- R10: Reads from any other offset, from a routing-word offset at or beyond the source count, or from a bank above the core count return 0. Writes to them change no state.
- R11: A change on an interrupt input reaches the IRQ outputs and the acknowledge value one clock edge later, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_cpu_sel | input | 1 | 0 selects the global region, 1 selects the banked per-core region |
| bus_addr | input | 12 | Byte offset within the selected region |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register (combinational) |
| priv_irq | input | NCPU*32 | Private level inputs; bits [32c+31:32c] belong to core c |
| shr_irq | input | NSRC-32 | Shared level inputs; bit i is source 32+i |
| cpu_irq | output | NCPU | Level IRQ output for each core |

## Verification
The main stimulus is a sweep over every shared source. Each source is routed to a single core, chosen from the source number. One pass of the sweep shows whether routing and enables are decoded per source, and whether a source reaches any core it was not routed to. A second sweep raises all shared sources above a moving threshold. This separates a correct lowest-number winner from an encoder that picks the highest source or loses one. A per-core private sweep and a mixed private-plus-shared pattern show whether masks stay in their own bank and whether private numbers win over shared ones. Out-of-range source numbers that alias onto real sources when truncated, and out-of-range routing offsets, expose decoders that drop upper address or data bits.

// File: rtl/icc_pkg.sv
package icc_pkg;

    localparam int ADDR_W  = 12;
    localparam int ID_W    = 10;
    localparam int PRIV_N  = 32;
    localparam int MAX_CPU = 4;
    localparam int PRI_W   = 4;

    localparam logic [ID_W-1:0]   NO_SRC   = 10'h3FF;
    localparam logic [ADDR_W-1:0] WORD_BASE = 12'h100;

    // global region offsets
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_EN_SET = 12'h030;
    localparam logic [ADDR_W-1:0] OFS_EN_CLR = 12'h034;

    // per-core bank offsets (low byte)
    localparam logic [7:0] OFS_CAUSE   = 8'h10;
    localparam logic [7:0] OFS_TASKPRI = 8'h40;
    localparam logic [7:0] OFS_ACK     = 8'h44;
    localparam logic [7:0] OFS_MSK_SET = 8'h48;
    localparam logic [7:0] OFS_MSK_CLR = 8'h4C;

    typedef enum logic [3:0] {
        RG_NONE,
        RG_CTRL,
        RG_EN_SET,
        RG_EN_CLR,
        RG_ROUTE,
        RG_CAUSE,
        RG_TASKPRI,
        RG_ACK,
        RG_MSK_SET,
        RG_MSK_CLR
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e       kind;
        logic [ID_W-1:0] idx;
        logic [1:0]      cpu;
    } reg_sel_t;

    function automatic reg_sel_t decode_addr(input logic bank,
                                             input logic [ADDR_W-1:0] a,
                                             input int ncpu,
                                             input int nsrc);
        reg_sel_t          s;
        logic [ADDR_W-1:0] off;
        int                widx;
        s.kind = RG_NONE;
        s.idx  = '0;
        s.cpu  = a[9:8];
        off    = a - WORD_BASE;
        widx   = int'(off >> 2);
        if (!bank) begin
            if (a == OFS_CTRL)
                s.kind = RG_CTRL;
            else if (a == OFS_EN_SET)
                s.kind = RG_EN_SET;
            else if (a == OFS_EN_CLR)
                s.kind = RG_EN_CLR;
            else if (a >= WORD_BASE && off[1:0] == 2'b00 && widx < nsrc) begin
                s.kind = RG_ROUTE;
                s.idx  = ID_W'(widx);
            end
        end else if (a[ADDR_W-1:10] == '0 && int'(a[9:8]) < ncpu) begin
            case (a[7:0])
                OFS_CAUSE:   s.kind = RG_CAUSE;
                OFS_TASKPRI: s.kind = RG_TASKPRI;
                OFS_ACK:     s.kind = RG_ACK;
                OFS_MSK_SET: s.kind = RG_MSK_SET;
                OFS_MSK_CLR: s.kind = RG_MSK_CLR;
                default:     s.kind = RG_NONE;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/icc_bus_decode.sv
module icc_bus_decode
    import icc_pkg::*;
#(
    parameter int NCPU = 4,
    parameter int NSRC = 64
) (
    input  logic              bus_cpu_sel,
    input  logic [ADDR_W-1:0] bus_addr,
    output reg_sel_t          sel
);
    always_comb begin
        sel = decode_addr(bus_cpu_sel, bus_addr, NCPU, NSRC);
    end
endmodule

// File: rtl/icc_src_bank.sv
module icc_src_bank
    import icc_pkg::*;
#(
    parameter int NCPU = 4,
    parameter int NSRC = 64
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       bus_wr,
    input  reg_kind_e                  kind,
    input  logic [ID_W-1:0]            idx,
    input  logic [ID_W-1:0]            wid,
    input  logic [NCPU-1:0]            wroute,
    input  logic [NSRC-PRIV_N-1:0]     shr_irq,
    output logic [NSRC-PRIV_N-1:0]     shr_live,
    output logic [NSRC-1:0][NCPU-1:0]  route_map
);
    localparam int NSH = NSRC - PRIV_N;

    logic [NSH-1:0] pend_q;
    logic [NSH-1:0] en_q;

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= shr_irq;
    end

    for (genvar i = 0; i < NSH; i++) begin : g_en
        always_ff @(posedge clk) begin
            if (rst)
                en_q[i] <= 1'b0;
            else if (bus_wr && kind == RG_EN_SET && wid == ID_W'(PRIV_N + i))
                en_q[i] <= 1'b1;
            else if (bus_wr && kind == RG_EN_CLR && wid == ID_W'(PRIV_N + i))
                en_q[i] <= 1'b0;
        end
    end

    for (genvar n = 0; n < NSRC; n++) begin : g_route
        always_ff @(posedge clk) begin
            if (rst)
                route_map[n] <= '0;
            else if (bus_wr && kind == RG_ROUTE && idx == ID_W'(n))
                route_map[n] <= wroute;
        end
    end

    assign shr_live = pend_q & en_q;
endmodule

// File: rtl/icc_cpu_port.sv
module icc_cpu_port
    import icc_pkg::*;
#(
    parameter int NSRC   = 64,
    parameter int CPU_ID = 0
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   ctrl_en,
    input  logic                   bus_wr,
    input  reg_kind_e              kind,
    input  logic [1:0]             cpu,
    input  logic [ID_W-1:0]        wid,
    input  logic [PRI_W-1:0]       wpri,
    input  logic [PRIV_N-1:0]      priv_irq,
    input  logic [NSRC-PRIV_N-1:0] shr_live,
    input  logic [NSRC-1:0]        route_col,
    output logic [ID_W-1:0]        ack_id,
    output logic                   irq,
    output logic [PRIV_N-1:0]      cause,
    output logic [PRI_W-1:0]       taskpri
);
    logic              mine;
    logic [PRIV_N-1:0] pend_q;
    logic [PRIV_N-1:0] mask_q;
    logic [NSRC-1:0]   dv;

    assign mine = (cpu == 2'(CPU_ID));

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= priv_irq;
    end

    for (genvar i = 0; i < PRIV_N; i++) begin : g_mask
        always_ff @(posedge clk) begin
            if (rst)
                mask_q[i] <= 1'b1;
            else if (bus_wr && mine && kind == RG_MSK_SET && wid == ID_W'(i))
                mask_q[i] <= 1'b1;
            else if (bus_wr && mine && kind == RG_MSK_CLR && wid == ID_W'(i))
                mask_q[i] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            taskpri <= '1;
        else if (bus_wr && mine && kind == RG_TASKPRI)
            taskpri <= wpri;
    end

    always_comb begin
        dv = '0;
        if (ctrl_en)
            dv = {shr_live & route_col[NSRC-1:PRIV_N], pend_q & ~mask_q};
    end

    always_comb begin
        ack_id = NO_SRC;
        for (int n = NSRC - 1; n >= 0; n--)
            if (dv[n]) ack_id = ID_W'(n);
    end

    assign irq   = |dv;
    assign cause = pend_q;
endmodule

// File: rtl/icc_top.sv
module icc_top
    import icc_pkg::*;
#(
    parameter int NCPU = 4,
    parameter int NSRC = 64
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   bus_wr,
    input  logic                   bus_cpu_sel,
    input  logic [11:0]            bus_addr,
    input  logic [31:0]            bus_wdata,
    output logic [31:0]            bus_rdata,
    input  logic [NCPU*32-1:0]     priv_irq,
    input  logic [NSRC-33:0]       shr_irq,
    output logic [NCPU-1:0]        cpu_irq
);
    localparam int NSH   = NSRC - PRIV_N;
    localparam int SRC_W = $clog2(NSRC);
    localparam logic [ID_W-1:0] NSRC_FIELD = ID_W'(NSRC);

    reg_sel_t                           sel;
    logic                               ctrl_en;
    logic [NSH-1:0]                     shr_live;
    logic [NSRC-1:0][NCPU-1:0]          route_map;
    logic [MAX_CPU-1:0][ID_W-1:0]       cpu_ack;
    logic [MAX_CPU-1:0][PRIV_N-1:0]     cpu_cause;
    logic [MAX_CPU-1:0][PRI_W-1:0]      cpu_pri;
    logic [ID_W-1:0]                    wid;

    assign wid = bus_wdata[ID_W-1:0];

    icc_bus_decode #(.NCPU(NCPU), .NSRC(NSRC)) u_dec (
        .bus_cpu_sel (bus_cpu_sel),
        .bus_addr    (bus_addr),
        .sel         (sel)
    );

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_en <= 1'b0;
        else if (bus_wr && sel.kind == RG_CTRL)
            ctrl_en <= bus_wdata[0];
    end

    icc_src_bank #(.NCPU(NCPU), .NSRC(NSRC)) u_src (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .kind      (sel.kind),
        .idx       (sel.idx),
        .wid       (wid),
        .wroute    (bus_wdata[NCPU-1:0]),
        .shr_irq   (shr_irq),
        .shr_live  (shr_live),
        .route_map (route_map)
    );

    for (genvar c = 0; c < MAX_CPU; c++) begin : g_cpu
        if (c < NCPU) begin : g_on
            logic [NSRC-1:0] col;
            for (genvar n = 0; n < NSRC; n++) begin : g_col
                assign col[n] = route_map[n][c];
            end
            icc_cpu_port #(.NSRC(NSRC), .CPU_ID(c)) u_port (
                .clk       (clk),
                .rst       (rst),
                .ctrl_en   (ctrl_en),
                .bus_wr    (bus_wr),
                .kind      (sel.kind),
                .cpu       (sel.cpu),
                .wid       (wid),
                .wpri      (bus_wdata[PRI_W-1:0]),
                .priv_irq  (priv_irq[c*PRIV_N +: PRIV_N]),
                .shr_live  (shr_live),
                .route_col (col),
                .ack_id    (cpu_ack[c]),
                .irq       (cpu_irq[c]),
                .cause     (cpu_cause[c]),
                .taskpri   (cpu_pri[c])
            );
        end else begin : g_off
            assign cpu_ack[c]   = NO_SRC;
            assign cpu_cause[c] = '0;
            assign cpu_pri[c]   = '0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (sel.kind)
            RG_CTRL:    bus_rdata = 32'({NSRC_FIELD, 1'b0, ctrl_en});
            RG_ROUTE:   bus_rdata = 32'(route_map[sel.idx[SRC_W-1:0]]);
            RG_CAUSE:   bus_rdata = 32'(cpu_cause[sel.cpu]);
            RG_TASKPRI: bus_rdata = 32'(cpu_pri[sel.cpu]);
            RG_ACK:     bus_rdata = 32'(cpu_ack[sel.cpu]);
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/icc_chk.sv
module icc_chk
    import icc_pkg::*;
#(
    parameter int NCPU = 4,
    parameter int NSRC = 64
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         ctrl_en,
    input logic [NCPU-1:0]              cpu_irq,
    input logic [NCPU*32-1:0]           priv_irq,
    input logic [NSRC-33:0]             shr_irq,
    input logic [MAX_CPU-1:0][ID_W-1:0] cpu_ack
);
    for (genvar c = 0; c < NCPU; c++) begin : g_c
        // R7: the OR output agrees with the separate priority encoder
        assert_irq_matches_ack_R7: assert property (@(posedge clk) disable iff (rst)
            cpu_irq[c] == (cpu_ack[c] != NO_SRC));
        // R6: winner is a real source or the idle code
        assert_ack_in_range_R6: assert property (@(posedge clk) disable iff (rst)
            (cpu_ack[c] == NO_SRC) || (int'(cpu_ack[c]) < NSRC));
    end

    assert_disabled_silent_R2: assert property (@(posedge clk) disable iff (rst)
        !ctrl_en |-> cpu_irq == '0);

    assert_quiet_inputs_R11: assert property (@(posedge clk) disable iff (rst)
        (shr_irq == '0 && priv_irq == '0) |=> cpu_irq == '0);
endmodule

bind icc_top icc_chk #(.NCPU(NCPU), .NSRC(NSRC)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ctrl_en  (ctrl_en),
    .cpu_irq  (cpu_irq),
    .priv_irq (priv_irq),
    .shr_irq  (shr_irq),
    .cpu_ack  (cpu_ack)
);

// File: tb/icc_top_tb.sv
module icc_top_tb;
    localparam int NCPU = 4;
    localparam int NSRC = 64;
    localparam int NSH  = NSRC - 32;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 bus_wr = 1'b0;
    logic                 bus_cpu_sel = 1'b0;
    logic [11:0]          bus_addr = '0;
    logic [31:0]          bus_wdata = '0;
    logic [31:0]          bus_rdata;
    logic [NCPU*32-1:0]   priv_irq = '0;
    logic [NSH-1:0]       shr_irq = '0;
    logic [NCPU-1:0]      cpu_irq;

    int checks = 0;
    int errs   = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    icc_top #(.NCPU(NCPU), .NSRC(NSRC)) u_dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_cpu_sel(bus_cpu_sel),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .priv_irq(priv_irq), .shr_irq(shr_irq), .cpu_irq(cpu_irq)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errs++;
            $display("FAIL %s got %h exp %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic bank, input int a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_cpu_sel = bank; bus_addr = 12'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic bank, input int a, output logic [31:0] v);
        @(negedge clk);
        bus_cpu_sel = bank; bus_addr = 12'(a);
        #1 v = bus_rdata;
    endtask

    task automatic settle();
        @(negedge clk);
        @(negedge clk);
    endtask

    function automatic logic [31:0] onehot_irq(input int k, input int c);
        return 32'(k == c);
    endfunction

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++; errs++;
            $display("FAIL watchdog got timeout exp completion");
            $display("CHECKS %0d ERRORS %0d", checks, errs);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq", 32'(cpu_irq), 32'h0);
        for (int c = 0; c < NCPU; c++) begin
            rd(1'b1, c * 256 + 'h44, v); chk("R1 ack", v, 32'h3FF);
            rd(1'b1, c * 256 + 'h40, v); chk("R1 taskpri", v, 32'hF);
        end
        rd(1'b0, 'h100 + 4 * 40, v); chk("R1 route", v, 32'h0);
        rd(1'b0, 'h0, v); chk("R2 ctrl off", v, 32'(NSRC << 2));

        wr(1'b0, 'h0, 32'hFFFF_FFFF);
        rd(1'b0, 'h0, v); chk("R2 ctrl on", v, 32'(NSRC << 2) | 32'h1);

        // R3/R5/R6/R7 sweep over every shared source, routed to one core
        for (int n = 32; n < NSRC; n++) begin
            wr(1'b0, 'h100 + 4 * n, 32'(1 << (n % NCPU)));
            wr(1'b0, 'h30, 32'(n));
            shr_irq = NSH'(1) << (n - 32);
            settle();
            for (int k = 0; k < NCPU; k++) begin
                chk("R7 route irq", 32'(cpu_irq[k]), onehot_irq(k, n % NCPU));
                rd(1'b1, k * 256 + 'h44, v);
                chk("R5 route ack", v, (k == n % NCPU) ? 32'(n) : 32'h3FF);
            end
            wr(1'b0, 'h34, 32'(n));
            @(negedge clk);
            chk("R3 clear enable", 32'(cpu_irq), 32'h0);
            shr_irq = '0;
        end

        // R5 readback width
        wr(1'b0, 'h100 + 4 * 40, 32'hFFFF_FFFF);
        rd(1'b0, 'h100 + 4 * 40, v); chk("R5 readback", v, 32'hF);

        // R6 lowest winner across thresholds
        for (int n = 32; n < NSRC; n++) begin
            wr(1'b0, 'h100 + 4 * n, 32'hF);
            wr(1'b0, 'h30, 32'(n));
        end
        for (int t = 32; t < NSRC; t++) begin
            shr_irq = '1 << (t - 32);
            settle();
            chk("R7 all", 32'(cpu_irq), 32'hF);
            for (int k = 0; k < NCPU; k++) begin
                rd(1'b1, k * 256 + 'h44, v); chk("R6 lowest", v, 32'(t));
            end
        end

        // R3 out-of-range ids, R4 shared id on mask register
        shr_irq = '1;
        settle();
        wr(1'b0, 'h34, 32'(96));
        wr(1'b0, 'h34, 32'(0));
        wr(1'b1, 'h48, 32'(32));
        rd(1'b1, 'h44, v); chk("R3 ignored ids", v, 32'(32));

        // R11 latency on a change of input
        shr_irq = '0;
        settle();
        @(negedge clk);
        shr_irq = NSH'(1);
        #1 chk("R11 not early", 32'(cpu_irq), 32'h0);
        @(negedge clk);
        chk("R11 one edge", 32'(cpu_irq), 32'hF);
        shr_irq = '0;

        // R10 unmapped accesses
        wr(1'b0, 'h8, 32'hFFFF_FFFF);
        rd(1'b0, 'h8, v); chk("R10 global hole", v, 32'h0);
        rd(1'b1, 'h0C, v); chk("R10 bank hole", v, 32'h0);
        rd(1'b1, 'h400, v); chk("R10 bank range", v, 32'h0);
        wr(1'b0, 'h100 + 4 * NSRC, 32'hF);
        rd(1'b0, 'h100 + 4 * NSRC, v); chk("R10 word range", v, 32'h0);
        rd(1'b0, 'h100, v); chk("R10 no alias", v, 32'h0);

        // R8 cause and R4 per-core masks
        for (int c = 0; c < NCPU; c++) begin
            priv_irq[c * 32 + c + 1] = 1'b1;
            priv_irq[c * 32 + 20]    = 1'b1;
        end
        settle();
        for (int c = 0; c < NCPU; c++) begin
            rd(1'b1, c * 256 + 'h10, v);
            chk("R8 cause", v, 32'((1 << (c + 1)) | (1 << 20)));
        end
        chk("R4 all masked", 32'(cpu_irq), 32'h0);
        wr(1'b1, 2 * 256 + 'h4C, 32'(20));
        @(negedge clk);
        chk("R4 own bank", 32'(cpu_irq), 32'h4);
        wr(1'b1, 2 * 256 + 'h4C, 32'(3));
        rd(1'b1, 2 * 256 + 'h44, v); chk("R4 unmask 3", v, 32'(3));
        wr(1'b1, 2 * 256 + 'h48, 32'(3));
        rd(1'b1, 2 * 256 + 'h44, v); chk("R4 remask", v, 32'(20));
        shr_irq = NSH'(1);
        settle();
        rd(1'b1, 2 * 256 + 'h44, v); chk("R6 private first", v, 32'(20));
        rd(1'b1, 0 * 256 + 'h44, v); chk("R6 shared other", v, 32'(32));

        // R2 disable gates all delivery
        wr(1'b0, 'h0, 32'h0);
        @(negedge clk);
        chk("R2 off irq", 32'(cpu_irq), 32'h0);
        rd(1'b1, 2 * 256 + 'h44, v); chk("R2 off ack", v, 32'h3FF);
        wr(1'b0, 'h0, 32'h1);
        shr_irq = '0;
        wr(1'b1, 2 * 256 + 'h48, 32'(20));
        priv_irq = '0;
        settle();

        // R4 private sweep on core 0
        for (int n = 0; n < 32; n++) begin
            priv_irq = (NCPU*32)'(1) << n;
            wr(1'b1, 'h4C, 32'(n));
            @(negedge clk);
            rd(1'b1, 'h44, v); chk("R4 sweep ack", v, 32'(n));
            chk("R7 sweep irq", 32'(cpu_irq), 32'h1);
            wr(1'b1, 'h48, 32'(n));
            @(negedge clk);
            chk("R4 sweep masked", 32'(cpu_irq), 32'h0);
        end
        priv_irq = '0;

        // R9 task priority
        wr(1'b1, 1 * 256 + 'h40, 32'h0);
        rd(1'b1, 1 * 256 + 'h40, v); chk("R9 zero", v, 32'h0);
        wr(1'b1, 1 * 256 + 'h40, 32'h35);
        rd(1'b1, 1 * 256 + 'h40, v); chk("R9 width", v, 32'h5);
        shr_irq = NSH'(1);
        settle();
        chk("R9 no effect", 32'(cpu_irq), 32'hF);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errs);
        $finish;
    end
endmodule